// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART's host data register, its line-side receive stream and its receive and transmit FIFOs. A two-bit channel mode decides where bytes go. Bytes from the line can go to the receive FIFO, to the transmit FIFO, to both, or be consumed and discarded. Host writes to the data register can go to the transmit FIFO, to the receive FIFO, or be dropped. The FIFOs and the bit-level serialiser live outside. The block reads the FIFO occupancy counts and produces one registered push strobe with data for each FIFO.

The line-side input uses a valid/ready handshake. The block computes how many bytes the line may still deliver. That figure is the smallest free space among the FIFOs the current mode feeds. A push that has been issued but is not yet counted is treated as already occupying its slot. When the mode feeds no FIFO, the figure is the larger of the two FIFO depths. Ready is raised whenever that figure is at least one.

Top module: `uart_chan_router`

## Requirements
- R1: The mode input `chan_mode` encodes 0 as normal, 1 as automatic echo, 2 as local loopback and 3 as remote loopback.
- R2: In normal mode, a byte accepted from the line appears on `rx_push`/`rx_push_data` in the cycle after the handshake. A host write appears on `tx_push`/`tx_push_data` in the cycle after the write.
- R3: In echo mode, an accepted line byte is pushed into both FIFOs in the same cycle, with identical data. A host write is dropped.
- R4: In local loopback, a host write is pushed into the receive FIFO in the next cycle. Line bytes are accepted and discarded without any push.
- R5: In remote loopback, an accepted line byte is pushed into the transmit FIFO only. A host write is dropped.
- R6: `line_space` equals the minimum free space over the FIFOs fed by the line in the current mode. Free space is depth minus count minus any push strobe currently asserted towards that FIFO.
- R7: In local loopback, `line_space` equals the larger of RX_DEPTH and TX_DEPTH.
- R8: `line_ready` is high exactly when `line_space` is at least one. No push results from `line_valid` while `line_ready` is low.
- R9: A host write whose target FIFO has no free space, counted as in R6, is dropped.
- R10: The mode present in the cycle of a handshake or host write decides that byte's routing. A mode change affects only later bytes.
- R11: While reset is high, and in the first cycle after it, both push strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_mode | input | 2 | Channel mode field |
| host_wr | input | 1 | Host write strobe to the data register |
| host_wdata | input | DATA_W | Host write data |
| line_valid | input | 1 | Line-side byte valid |
| line_data | input | DATA_W | Line-side byte |
| line_ready | output | 1 | Line side may deliver a byte |
| line_space | output | CNT_W | Bytes the line may still deliver |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_push | output | 1 | Push strobe into the receive FIFO |
| rx_push_data | output | DATA_W | Data for the receive FIFO |
| tx_push | output | 1 | Push strobe into the transmit FIFO |
| tx_push_data | output | DATA_W | Data for the transmit FIFO |

## Verification
The hardest case to reach is a FIFO standing at depth minus one while a push is still in flight towards it. This is where the pending strobe alone must withhold `line_ready` or drop a host write. The bench models both FIFOs as counters that it feeds from the push strobes. It runs fill phases in each mode with popping switched off, so the counts climb into that last slot with line and host traffic arriving every cycle. Later phases change the mode on every cycle to exercise per-byte mode sampling.

// File: rtl/ucr_pkg.sv
package ucr_pkg;

    typedef enum logic [1:0] {
        CM_NORMAL = 2'd0,
        CM_ECHO   = 2'd1,
        CM_LOCAL  = 2'd2,
        CM_REMOTE = 2'd3
    } chan_mode_e;

    typedef struct packed {
        logic to_rx;
        logic to_tx;
    } route_t;

    function automatic route_t line_route(chan_mode_e m);
        route_t r;
        r.to_rx = (m == CM_NORMAL) || (m == CM_ECHO);
        r.to_tx = (m == CM_REMOTE) || (m == CM_ECHO);
        return r;
    endfunction

    function automatic route_t host_route(chan_mode_e m);
        route_t r;
        r.to_rx = (m == CM_LOCAL);
        r.to_tx = (m == CM_NORMAL);
        return r;
    endfunction

    function automatic int free_of(int depth, int cnt, int pend);
        int used;
        used = cnt + pend;
        return (used >= depth) ? 0 : depth - used;
    endfunction

    function automatic int min_int(int a, int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/ucr_route_dec.sv
module ucr_route_dec
    import ucr_pkg::*;
(
    input  logic [1:0] mode,
    output route_t     line_rt,
    output route_t     host_rt
);
    chan_mode_e m;

    always_comb begin
        m       = chan_mode_e'(mode);
        line_rt = line_route(m);
        host_rt = host_route(m);
    end
endmodule

// File: rtl/ucr_space_calc.sv
module ucr_space_calc
    import ucr_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 8,
    parameter int CNT_W    = 5
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_pend,
    input  logic             tx_pend,
    input  route_t           line_rt,
    output logic [CNT_W-1:0] rx_free,
    output logic [CNT_W-1:0] tx_free,
    output logic [CNT_W-1:0] line_space,
    output logic             line_ready
);
    localparam int MAX_DEPTH = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH;

    int rx_f, tx_f, sp;

    always_comb begin
        rx_f = free_of(RX_DEPTH, int'(rx_count), int'(rx_pend));
        tx_f = free_of(TX_DEPTH, int'(tx_count), int'(tx_pend));
        sp   = MAX_DEPTH;
        if (line_rt.to_rx) sp = min_int(sp, rx_f);
        if (line_rt.to_tx) sp = min_int(sp, tx_f);
        rx_free    = CNT_W'(rx_f);
        tx_free    = CNT_W'(tx_f);
        line_space = CNT_W'(sp);
        line_ready = (sp > 0);
    end
endmodule

// File: rtl/ucr_push_stage.sv
module ucr_push_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_sel,
    input  logic [DATA_W-1:0] line_data,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_data,
    output logic              push_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            push_q <= 1'b0;
            data_q <= '0;
        end else begin
            push_q <= line_sel | host_sel;
            if (line_sel)
                data_q <= line_data;
            else if (host_sel)
                data_q <= host_data;
        end
    end
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import ucr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 8,
    localparam int MAX_DEPTH = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
    localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        chan_mode,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              line_valid,
    input  logic [DATA_W-1:0] line_data,
    output logic              line_ready,
    output logic [CNT_W-1:0]  line_space,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_push_data,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_push_data
);
    route_t           line_rt, host_rt;
    logic [CNT_W-1:0] rx_free, tx_free;
    logic             line_hs;
    logic             rx_line_sel, rx_host_sel, tx_line_sel, tx_host_sel;

    ucr_route_dec u_dec (
        .mode    (chan_mode),
        .line_rt (line_rt),
        .host_rt (host_rt)
    );

    ucr_space_calc #(
        .RX_DEPTH (RX_DEPTH),
        .TX_DEPTH (TX_DEPTH),
        .CNT_W    (CNT_W)
    ) u_space (
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .rx_pend    (rx_push),
        .tx_pend    (tx_push),
        .line_rt    (line_rt),
        .rx_free    (rx_free),
        .tx_free    (tx_free),
        .line_space (line_space),
        .line_ready (line_ready)
    );

    always_comb begin
        line_hs     = line_valid & line_ready;
        rx_line_sel = line_hs & line_rt.to_rx;
        tx_line_sel = line_hs & line_rt.to_tx;
        rx_host_sel = host_wr & host_rt.to_rx & (rx_free != '0);
        tx_host_sel = host_wr & host_rt.to_tx & (tx_free != '0);
    end

    ucr_push_stage #(.DATA_W(DATA_W)) u_rx_stage (
        .clk       (clk),
        .rst       (rst),
        .line_sel  (rx_line_sel),
        .line_data (line_data),
        .host_sel  (rx_host_sel),
        .host_data (host_wdata),
        .push_q    (rx_push),
        .data_q    (rx_push_data)
    );

    ucr_push_stage #(.DATA_W(DATA_W)) u_tx_stage (
        .clk       (clk),
        .rst       (rst),
        .line_sel  (tx_line_sel),
        .line_data (line_data),
        .host_sel  (tx_host_sel),
        .host_data (host_wdata),
        .push_q    (tx_push),
        .data_q    (tx_push_data)
    );
endmodule

// File: rtl/ucr_chk.sv
module ucr_chk #(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 8,
    localparam int MAX_DEPTH = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
    localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        chan_mode,
    input logic              host_wr,
    input logic              line_valid,
    input logic              line_ready,
    input logic [CNT_W-1:0]  line_space,
    input logic              rx_push,
    input logic [DATA_W-1:0] rx_push_data,
    input logic              tx_push,
    input logic [DATA_W-1:0] tx_push_data
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        // R11
        if (rst_q == 1'b1) begin
            reset_quiet_chk: assert (!rx_push && !tx_push);
        end
    end

    // R3
    echo_both_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_mode == 2'd1 && line_valid && line_ready)
        |=> (rx_push && tx_push && rx_push_data == tx_push_data));

    // R5
    remote_tx_only_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_mode == 2'd3 && line_valid && line_ready)
        |=> (tx_push && !rx_push));

    // R4
    local_line_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_mode == 2'd2 && !host_wr) |=> (!rx_push && !tx_push));

    // R7
    local_space_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_mode == 2'd2) |-> (int'(line_space) == MAX_DEPTH));

    // R2
    normal_host_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_mode == 2'd0 && host_wr && !line_valid) |=> !rx_push);
endmodule

bind uart_chan_router ucr_chk #(
    .DATA_W   (DATA_W),
    .RX_DEPTH (RX_DEPTH),
    .TX_DEPTH (TX_DEPTH)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .chan_mode    (chan_mode),
    .host_wr      (host_wr),
    .line_valid   (line_valid),
    .line_ready   (line_ready),
    .line_space   (line_space),
    .rx_push      (rx_push),
    .rx_push_data (rx_push_data),
    .tx_push      (tx_push),
    .tx_push_data (tx_push_data)
);

// File: tb/tb_uart_chan_router.sv
`timescale 1ns/1ps
module tb_uart_chan_router;
    localparam int DW  = 8;
    localparam int RXD = 16;
    localparam int TXD = 8;
    localparam int MXD = (RXD > TXD) ? RXD : TXD;
    localparam int CW  = $clog2(MXD + 1);
    localparam int NCYC = 3200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]    chan_mode = 2'd0;
    logic          host_wr = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic          line_valid = 1'b0;
    logic [DW-1:0] line_data = '0;
    logic          line_ready;
    logic [CW-1:0] line_space;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_push, tx_push;
    logic [DW-1:0] rx_push_data, tx_push_data;

    int errors = 0;
    int checks = 0;
    int rxn = 0, txn = 0;
    logic pop_rx = 1'b0, pop_tx = 1'b0;

    logic          exp_rx = 1'b0, exp_tx = 1'b0;
    logic [DW-1:0] exp_rxd = '0, exp_txd = '0;
    string         tag_rx = "R11", tag_tx = "R11";

    always #2 clk = ~clk;

    assign rx_count = CW'(rxn);
    assign tx_count = CW'(txn);

    uart_chan_router #(.DATA_W(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD)) dut (
        .clk(clk), .rst(rst), .chan_mode(chan_mode),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .line_valid(line_valid), .line_data(line_data),
        .line_ready(line_ready), .line_space(line_space),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_push(tx_push), .tx_push_data(tx_push_data)
    );

    // FIFO occupancy model: commits pushes and pops at the clock edge
    always @(posedge clk) begin
        if (rst) begin
            rxn <= 0;
            txn <= 0;
        end else begin
            rxn <= rxn + int'(rx_push) - ((pop_rx && rxn > 0) ? 1 : 0);
            txn <= txn + int'(tx_push) - ((pop_tx && txn > 0) ? 1 : 0);
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int rfree, tfree, space, prev_mode;
        bit lrx, ltx, hs, hrx, htx;
        repeat (3) begin
            @(negedge clk);
            check("R11", "rx_push in reset", int'(rx_push), 0);
            check("R11", "tx_push in reset", int'(tx_push), 0);
        end
        rst = 1'b0;
        prev_mode = 0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            int phase;
            @(negedge clk);
            // registered outputs for this cycle
            check(tag_rx, "rx_push", int'(rx_push), int'(exp_rx));
            check(tag_tx, "tx_push", int'(tx_push), int'(exp_tx));
            if (exp_rx) check({tag_rx, " R1"}, "rx_push_data", int'(rx_push_data), int'(exp_rxd));
            if (exp_tx) check({tag_tx, " R1"}, "tx_push_data", int'(tx_push_data), int'(exp_txd));

            // drive the next cycle's stimulus
            phase = cyc / 200;
            if (phase < 8) chan_mode = 2'(phase % 4);
            else           chan_mode = 2'($urandom_range(0, 3));
            pop_rx = (phase >= 4) && ($urandom_range(0, 3) != 0);
            pop_tx = (phase >= 4) && ($urandom_range(0, 2) != 0);
            host_wr    = ($urandom_range(0, 1) == 1);
            host_wdata = DW'($urandom);
            line_valid = ($urandom_range(0, 3) != 0);
            line_data  = DW'($urandom);
            #0.5;

            // space model from counts and the pushes now in flight
            rfree = RXD - rxn - int'(exp_rx); if (rfree < 0) rfree = 0;
            tfree = TXD - txn - int'(exp_tx); if (tfree < 0) tfree = 0;
            lrx = (chan_mode == 2'd0) || (chan_mode == 2'd1);
            ltx = (chan_mode == 2'd3) || (chan_mode == 2'd1);
            space = MXD;
            if (lrx && rfree < space) space = rfree;
            if (ltx && tfree < space) space = tfree;
            check((chan_mode == 2'd2) ? "R7" : "R6", "line_space", int'(line_space), space);
            check("R8", "line_ready", int'(line_ready), (space > 0) ? 1 : 0);

            // expected pushes for the next cycle
            hs  = line_valid && (space > 0);
            hrx = host_wr && (chan_mode == 2'd2) && (rfree > 0);
            htx = host_wr && (chan_mode == 2'd0) && (tfree > 0);
            exp_rx = (hs && lrx) || hrx;
            exp_tx = (hs && ltx) || htx;
            if (hs && lrx) exp_rxd = line_data; else if (hrx) exp_rxd = host_wdata;
            if (hs && ltx) exp_txd = line_data; else if (htx) exp_txd = host_wdata;
            case (chan_mode)
                2'd0: begin tag_rx = "R2"; tag_tx = "R2"; end
                2'd1: begin tag_rx = "R3"; tag_tx = "R3"; end
                2'd2: begin tag_rx = "R4"; tag_tx = "R4"; end
                default: begin tag_rx = "R5"; tag_tx = "R5"; end
            endcase
            if (host_wr && chan_mode == 2'd2 && rfree == 0) tag_rx = {tag_rx, " R9"};
            if (host_wr && chan_mode == 2'd0 && tfree == 0) tag_tx = {tag_tx, " R9"};
            if (line_valid && space == 0) begin
                tag_rx = {tag_rx, " R8"};
                tag_tx = {tag_tx, " R8"};
            end
            if (int'(chan_mode) != prev_mode) begin
                tag_rx = {tag_rx, " R10"};
                tag_tx = {tag_tx, " R10"};
            end
            prev_mode = int'(chan_mode);
        end
        @(negedge clk);
        check(tag_rx, "rx_push final", int'(rx_push), int'(exp_rx));
        check(tag_tx, "tx_push final", int'(tx_push), int'(exp_tx));
        summary();
    end
endmodule